// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds three tables of 2-bit saturating counters. A bimodal table is indexed by the low bits of the branch address. A gshare table is indexed by the global outcome history XORed with the low address bits. A chooser table, also indexed by the address, decides which of the two component guesses becomes the final answer.

On the fetch side, a strobe with a branch address gives a registered prediction one cycle later. That prediction comes with the two component guesses, so the pipeline can carry them to resolution. On the resolve side, the branch address, the real outcome and the carried component guesses train the addressed entry of each table. The same cycle shifts the outcome into the global history. History changes only at resolution and never on speculation.

Top module: `tourn_pred`

## Requirements
- R1: After reset every counter in all three tables holds 2'b10 (weak taken), and the global history is all zeros. A lookup right after reset therefore returns final, bimodal and gshare predictions of 1.
- R2: A resolved taken outcome increments the addressed bimodal and gshare counters. A counter at 2'b11 stays at 2'b11.
- R3: A resolved not-taken outcome decrements the addressed bimodal and gshare counters. A counter at 2'b00 stays at 2'b00.
- R4: A component prediction is the MSB of its counter (1 = taken). The bimodal counter is selected by address bits [BIM_W-1:0].
- R5: The gshare counter is selected by history XOR address bits [HIST_W-1:0]. Both lookup and training use the history value held at that moment.
- R6: The chooser counter is selected by address bits [CHO_W-1:0]. Its MSB = 1 selects the bimodal prediction and 0 selects the gshare prediction.
- R7: At resolution, the chooser counter increments (saturating at 2'b11) when the carried bimodal guess matches the outcome and the carried gshare guess does not. It decrements (saturating at 2'b00) in the opposite case, and otherwise holds.
- R8: On each resolve strobe the history shifts left by one place and the outcome enters bit 0. Without a strobe it holds.
- R9: Outputs appear one cycle after the predict strobe, with pred_valid_o high. A lookup in the same cycle as a resolve sees the state before that update. Without a strobe, pred_valid_o is low and the prediction outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_valid_i | input | 1 | Lookup strobe |
| pred_pc_i | input | ADDR_W | Branch address to predict |
| pred_valid_o | output | 1 | Prediction outputs are fresh |
| pred_taken_o | output | 1 | Final prediction |
| pred_bim_o | output | 1 | Bimodal component prediction |
| pred_gsh_o | output | 1 | Gshare component prediction |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | ADDR_W | Address of the resolved branch |
| res_taken_i | input | 1 | Actual outcome |
| res_bim_i | input | 1 | Bimodal guess carried from fetch |
| res_gsh_i | input | 1 | Gshare guess carried from fetch |

## Verification
The assertions assume that the strobes and their payloads are stable, known values at each rising edge, and that reset is asserted long enough for the tables to clear. They do not assume that the carried guesses are the ones the block actually made. The chooser update is checked as a function of the carried values alone.

The stimulus is driven one time unit after each rising edge. It draws addresses from a narrow range so that table entries repeat and counters reach both saturation limits. Carried guesses and outcomes are drawn freely, so all four agree/disagree combinations reach the chooser.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RST = 2'b10;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_inc_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RST;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= ctr_step(mem[wr_idx_i], wr_inc_i);
    end
  end

  assign rd_ctr_o = mem[rd_idx_i];

  // R2: increment saturates at 11
  assert_inc_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_inc_i |=> mem[$past(wr_idx_i)] ==
      (($past(mem[wr_idx_i]) == 2'b11) ? 2'b11 : $past(mem[wr_idx_i]) + 2'd1));

  // R3: decrement saturates at 00
  assert_dec_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_inc_i |=> mem[$past(wr_idx_i)] ==
      (($past(mem[wr_idx_i]) == 2'b00) ? 2'b00 : $past(mem[wr_idx_i]) - 2'd1));

  // R7: no write leaves entries untouched
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> mem[$past(rd_idx_i)] == $past(mem[rd_idx_i]));
endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_o <= '0;
    else if (upd_i) hist_o <= {hist_o[HIST_W-2:0], bit_i};
  end

  assert_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> hist_o == {$past(hist_o[HIST_W-2:0]), $past(bit_i)});

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(hist_o));
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BIM_W  = 10,
  parameter int HIST_W = 10,
  parameter int CHO_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_valid_i,
  input  logic [ADDR_W-1:0] pred_pc_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              pred_bim_o,
  output logic              pred_gsh_o,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic              res_taken_i,
  input  logic              res_bim_i,
  input  logic              res_gsh_i
);
  logic [HIST_W-1:0] ghr;
  ctr_t bim_ctr, gsh_ctr, cho_ctr;
  ctr_t unused_bim_wr, unused_gsh_wr, unused_cho_wr;
  logic unused_pc;
  logic bim_ok, gsh_ok;
  logic sel_bim;

  assign unused_pc = ^{pred_pc_i, res_pc_i, unused_bim_wr, unused_gsh_wr, unused_cho_wr};

  ghist_reg #(.HIST_W(HIST_W)) u_ghr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_i(res_valid_i), .bit_i(res_taken_i), .hist_o(ghr)
  );

  ctr_table #(.IDX_W(BIM_W)) u_bim (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(pred_pc_i[BIM_W-1:0]), .rd_ctr_o(bim_ctr),
    .wr_en_i(res_valid_i), .wr_idx_i(res_pc_i[BIM_W-1:0]), .wr_inc_i(res_taken_i)
  );

  ctr_table #(.IDX_W(HIST_W)) u_gsh (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(ghr ^ pred_pc_i[HIST_W-1:0]), .rd_ctr_o(gsh_ctr),
    .wr_en_i(res_valid_i), .wr_idx_i(ghr ^ res_pc_i[HIST_W-1:0]), .wr_inc_i(res_taken_i)
  );

  assign bim_ok = (res_bim_i == res_taken_i);
  assign gsh_ok = (res_gsh_i == res_taken_i);

  ctr_table #(.IDX_W(CHO_W)) u_cho (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(pred_pc_i[CHO_W-1:0]), .rd_ctr_o(cho_ctr),
    .wr_en_i(res_valid_i && (bim_ok != gsh_ok)),
    .wr_idx_i(res_pc_i[CHO_W-1:0]), .wr_inc_i(bim_ok)
  );

  assign unused_bim_wr = '0;
  assign unused_gsh_wr = '0;
  assign unused_cho_wr = '0;
  assign sel_bim = cho_ctr[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b1;
      pred_bim_o   <= 1'b1;
      pred_gsh_o   <= 1'b1;
    end else begin
      pred_valid_o <= pred_valid_i;
      if (pred_valid_i) begin
        pred_bim_o   <= bim_ctr[1];
        pred_gsh_o   <= gsh_ctr[1];
        pred_taken_o <= sel_bim ? bim_ctr[1] : gsh_ctr[1];
      end
    end
  end

  assert_valid_lat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o == $past(pred_valid_i));

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> $stable({pred_taken_o, pred_bim_o, pred_gsh_o}));

  assert_agree_pick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o && (pred_bim_o == pred_gsh_o) |-> pred_taken_o == pred_bim_o);
endmodule

// File: tb/sim_tourn_pred.sv
module sim_tourn_pred;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int BIM_W  = 10;
  localparam int HIST_W = 10;
  localparam int CHO_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pv = 1'b0, rv = 1'b0, rt = 1'b0, rb = 1'b0, rg = 1'b0;
  logic [ADDR_W-1:0] ppc = '0, rpc = '0;
  logic vo, to, bo, go;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0] m_bim [1<<BIM_W];
  logic [1:0] m_gsh [1<<HIST_W];
  logic [1:0] m_cho [1<<CHO_W];
  logic [HIST_W-1:0] m_ghr;
  logic e_t, e_b, e_g;

  tourn_pred #(.ADDR_W(ADDR_W), .BIM_W(BIM_W), .HIST_W(HIST_W), .CHO_W(CHO_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(pv), .pred_pc_i(ppc),
    .pred_valid_o(vo), .pred_taken_o(to), .pred_bim_o(bo), .pred_gsh_o(go),
    .res_valid_i(rv), .res_pc_i(rpc), .res_taken_i(rt), .res_bim_i(rb), .res_gsh_i(rg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic chk(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drives one cycle; model reflects state after the edge
  task automatic step(logic p, logic [ADDR_W-1:0] pa, logic r, logic [ADDR_W-1:0] ra,
                      logic t, logic b, logic g, string req);
    logic [HIST_W-1:0] gi;
    logic ob, og;
    logic p_t, p_b, p_g;
    p_t = e_t; p_b = e_b; p_g = e_g;
    pv = p; ppc = pa; rv = r; rpc = ra; rt = t; rb = b; rg = g;
    if (p) begin
      e_b = m_bim[pa[BIM_W-1:0]][1];
      e_g = m_gsh[m_ghr ^ pa[HIST_W-1:0]][1];
      e_t = m_cho[pa[CHO_W-1:0]][1] ? e_b : e_g;
    end
    if (r) begin
      gi = m_ghr ^ ra[HIST_W-1:0];
      m_bim[ra[BIM_W-1:0]] = sat(m_bim[ra[BIM_W-1:0]], t);
      m_gsh[gi] = sat(m_gsh[gi], t);
      ob = (b == t); og = (g == t);
      if (ob != og) m_cho[ra[CHO_W-1:0]] = sat(m_cho[ra[CHO_W-1:0]], ob);
      m_ghr = {m_ghr[HIST_W-2:0], t};
    end
    @(posedge clk);
    #1;
    chk(vo == p, "R9 valid", vo, p);
    if (p) begin
      chk(bo == e_b, {req, " bim"}, bo, e_b);
      chk(go == e_g, {req, " gsh"}, go, e_g);
      chk(to == e_t, {req, " final"}, to, e_t);
    end else begin
      chk({to, bo, go} == {p_t, p_b, p_g}, "R9 hold", {to, bo, go}, {p_t, p_b, p_g});
    end
  endtask

  initial begin
    logic a, b2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1<<BIM_W); i++) m_bim[i] = 2'b10;
    for (int i = 0; i < (1<<HIST_W); i++) m_gsh[i] = 2'b10;
    for (int i = 0; i < (1<<CHO_W); i++) m_cho[i] = 2'b10;
    m_ghr = '0;
    e_t = 1'b1; e_b = 1'b1; e_g = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(vo == 1'b0, "R1 valid low", vo, 0);

    // R1: reset state
    step(1, 32'h123, 0, 0, 0, 0, 0, "R1");
    // R2: three takens then one not-taken on one address
    for (int k = 0; k < 3; k++) step(0, 0, 1, 32'h5, 1, 1, 1, "R2");
    step(1, 32'h5, 1, 32'h5, 0, 1, 1, "R9 same-cycle");
    step(1, 32'h5, 0, 0, 0, 0, 0, "R2");
    // R3: drive counters to 00, then one taken
    for (int k = 0; k < 5; k++) step(0, 0, 1, 32'h7, 0, 0, 0, "R3");
    step(0, 0, 1, 32'h7, 1, 0, 0, "R3");
    step(1, 32'h7, 0, 0, 0, 0, 0, "R3 R4");
    // R7/R6: gshare right, bimodal wrong, twice -> chooser selects gshare
    step(0, 0, 1, 32'h9, 1, 0, 1, "R7");
    step(0, 0, 1, 32'h9, 1, 0, 1, "R7");
    step(1, 32'h9, 0, 0, 0, 0, 0, "R6 R7");
    // R7: both right keeps the chooser
    step(0, 0, 1, 32'h9, 0, 0, 0, "R7 hold");
    step(1, 32'h9, 0, 0, 0, 0, 0, "R7 hold");
    // R8 R5: history pattern shifts into gshare index
    for (int k = 0; k < 12; k++) step(0, 0, 1, 32'h40 + k, k[0], 0, 1, "R8");
    step(1, 32'h40, 0, 0, 0, 0, 0, "R5 R8");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      a  = ($urandom % 3) != 0;
      b2 = ($urandom % 2) != 0;
      step(a, $urandom % 24, b2, $urandom % 24, ($urandom % 4) != 0,
           $urandom % 2, $urandom % 2, "R4 R5 R6 R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule